// File: doc/BRIEF.md
# Receive Wake-Up Character Filter

This block sits after a UART receive deserializer and decides, for every completed character, whether the receive-ready flag gets set. A sleep control (`dormant`) and a multiprocessor format select (`mode`) govern the decision. While the block sleeps, only certain characters wake it:

- a character marked by its address bit;
- the first character after an idle line;
- in automatic-baud operation, a sync field that directly follows a break.

When the block is awake, every character passes. The block also conditions the raw receive line. It first synchronizes the line into the clock domain. It then applies a deglitch counter whose length is selectable, so that short spikes never reach the deserializer.

A software-reset input holds the block in a quiet state. That state has no pending qualifications, the filtered line sits at the idle (high) level, and no flag strobes are produced. The flag strobe is combinational from the character-done input and registered qualification state. It appears in the same cycle as character-done, so the surrounding receiver sees no added latency.

Top module: `rx_wake_filter`

## Requirements
- R1: While `sw_rst` is 1, `flag_set` stays 0, `rx_filt` is forced to 1 from the next clock edge, and any idle or break qualification seen before or during the reset is discarded.
- R2: With `sw_rst` 0 and `dormant` 0, every cycle with `char_done` 1 produces `flag_set` 1, in every mode.
- R3: In mode 0 (plain, no multiprocessor format), `dormant` has no effect and every completed character sets the flag.
- R4: In mode 1 (idle-line) with `dormant` 1, a character sets the flag only if `idle_det` was 1 in some earlier cycle after the previous completed character.
- R5: An idle qualification is used up by the next completed character, so a second character without a new `idle_det` does not set the flag.
- R6: In mode 2 (address-bit) with `dormant` 1, `flag_set` equals `addr_bit` in each `char_done` cycle.
- R7: In mode 3 (automatic baud) with `dormant` 1, a character sets the flag only when it arrives with `sync_ok` 1 and `brk_det` was 1 in an earlier cycle after the previous completed character.
- R8: In mode 3 with `dormant` 1, the following do not set the flag: a lone break, a sync without a preceding break, and a sync that follows a break with another character in between. Any completed character clears a pending break.
- R9: `dormant` is taken in the `char_done` cycle itself, so clearing it in that cycle lets the character set the flag.
- R10: `flag_set` is a single-cycle strobe and is never 1 in a cycle where `char_done` is 0.
- R11: `rx_filt` takes a new level of `rx_raw` exactly SYNC_STAGES + N clock edges after the raw change, where N is 1, 4, 6 or 10 for `glitch_sel` 0, 1, 2 or 3.
- R12: A raw pulse shorter than N clocks never changes `rx_filt`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_rst | input | 1 | Software hold; 1 keeps the block quiet and cleared |
| dormant | input | 1 | Sleep enable |
| mode | input | 2 | 0 plain, 1 idle-line, 2 address-bit, 3 automatic baud |
| glitch_sel | input | 2 | Deglitch length select (1, 4, 6, 10 clocks) |
| rx_raw | input | 1 | Asynchronous receive line |
| char_done | input | 1 | One-cycle strobe: a character has been completed |
| addr_bit | input | 1 | Address bit of the completed character |
| idle_det | input | 1 | One-cycle strobe: idle line detected |
| brk_det | input | 1 | One-cycle strobe: break detected |
| sync_ok | input | 1 | With char_done: the completed character was a valid sync field |
| rx_filt | output | 1 | Synchronized and deglitched receive line |
| flag_set | output | 1 | One-cycle strobe that sets the receive flag |

## Verification
The bench builds the block with its default parameters: two synchronizer stages, a 4-bit deglitch counter and lengths of 1, 4, 6 and 10 clocks. With these values all four lengths can be measured edge by edge within a few dozen cycles. The longest window of ten clocks is still short enough to sweep glitch widths just below each limit. The reference model tracks the pending idle and break qualifications on its own. This lets the bench compare every cycle of flag and filtered-line behaviour across all four modes, with the sleep control both set and cleared.

// File: rtl/rwf_pkg.sv
package rwf_pkg;

    typedef enum logic [1:0] {
        MODE_PLAIN    = 2'd0,
        MODE_IDLE     = 2'd1,
        MODE_ADDR     = 2'd2,
        MODE_AUTOBAUD = 2'd3
    } rwf_mode_e;

    typedef struct packed {
        logic idle_arm;
        logic brk_arm;
    } rwf_arm_t;

endpackage

// File: rtl/rwf_deglitch.sv
module rwf_deglitch #(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 4,
    parameter int LEN0        = 1,
    parameter int LEN1        = 4,
    parameter int LEN2        = 6,
    parameter int LEN3        = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic [1:0] sel,
    input  logic       din,
    output logic       dout
);

    localparam int NUM_LEN = 4;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [CNT_W-1:0]       cnt;
        logic                   lvl;
    } dg_state_t;

    localparam dg_state_t DG_RST = '{sync: '1, cnt: '0, lvl: 1'b1};

    logic [CNT_W-1:0] len_tab [NUM_LEN];
    logic [CNT_W-1:0] need;
    logic [CNT_W:0]   cnt_inc;
    logic             s_in;
    dg_state_t        st_d, st_q;

    generate
        for (genvar g = 0; g < NUM_LEN; g++) begin : g_len
            localparam int LV = (g == 0) ? LEN0 : (g == 1) ? LEN1 : (g == 2) ? LEN2 : LEN3;
            assign len_tab[g] = CNT_W'(LV);
        end
    endgenerate

    assign need    = len_tab[sel];
    assign s_in    = st_q.sync[SYNC_STAGES-1];
    assign cnt_inc = (CNT_W+1)'(st_q.cnt) + (CNT_W+1)'(1);

    always_comb begin
        st_d      = st_q;
        st_d.sync = SYNC_STAGES'({st_q.sync, din});
        if (s_in == st_q.lvl) begin
            st_d.cnt = '0;
        end else if (cnt_inc >= (CNT_W+1)'(need)) begin
            st_d.cnt = '0;
            st_d.lvl = s_in;
        end else begin
            st_d.cnt = cnt_inc[CNT_W-1:0];
        end
        if (clr) begin
            st_d = DG_RST;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= DG_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.lvl;

endmodule

// File: rtl/rwf_arm.sv
module rwf_arm
    import rwf_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     clr,
    input  logic     char_done,
    input  logic     idle_det,
    input  logic     brk_det,
    output rwf_arm_t arm
);

    rwf_arm_t arm_d, arm_q;

    always_comb begin
        arm_d          = arm_q;
        arm_d.idle_arm = idle_det | (arm_q.idle_arm & ~char_done);
        arm_d.brk_arm  = brk_det  | (arm_q.brk_arm  & ~char_done);
        if (clr) begin
            arm_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arm_q <= '0;
        end else begin
            arm_q <= arm_d;
        end
    end

    assign arm = arm_q;

endmodule

// File: rtl/rwf_decide.sv
module rwf_decide
    import rwf_pkg::*;
(
    input  logic      clr,
    input  logic      dormant,
    input  rwf_mode_e mode,
    input  logic      char_done,
    input  logic      addr_bit,
    input  logic      sync_ok,
    input  rwf_arm_t  arm,
    output logic      flag_set
);

    logic qual;

    always_comb begin
        unique case (mode)
            MODE_PLAIN:    qual = 1'b1;
            MODE_IDLE:     qual = arm.idle_arm;
            MODE_ADDR:     qual = addr_bit;
            MODE_AUTOBAUD: qual = arm.brk_arm & sync_ok;
            default:       qual = 1'b0;
        endcase
    end

    assign flag_set = ~clr & char_done & (~dormant | qual);

endmodule

// File: rtl/rx_wake_filter.sv
module rx_wake_filter
    import rwf_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 4,
    parameter int LEN0        = 1,
    parameter int LEN1        = 4,
    parameter int LEN2        = 6,
    parameter int LEN3        = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sw_rst,
    input  logic       dormant,
    input  logic [1:0] mode,
    input  logic [1:0] glitch_sel,
    input  logic       rx_raw,
    input  logic       char_done,
    input  logic       addr_bit,
    input  logic       idle_det,
    input  logic       brk_det,
    input  logic       sync_ok,
    output logic       rx_filt,
    output logic       flag_set
);

    rwf_arm_t  arm;
    rwf_mode_e mode_e;

    assign mode_e = rwf_mode_e'(mode);

    rwf_deglitch #(
        .SYNC_STAGES (SYNC_STAGES),
        .CNT_W       (CNT_W),
        .LEN0        (LEN0),
        .LEN1        (LEN1),
        .LEN2        (LEN2),
        .LEN3        (LEN3)
    ) u_deglitch (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (sw_rst),
        .sel   (glitch_sel),
        .din   (rx_raw),
        .dout  (rx_filt)
    );

    rwf_arm u_arm (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (sw_rst),
        .char_done (char_done),
        .idle_det  (idle_det),
        .brk_det   (brk_det),
        .arm       (arm)
    );

    rwf_decide u_decide (
        .clr       (sw_rst),
        .dormant   (dormant),
        .mode      (mode_e),
        .char_done (char_done),
        .addr_bit  (addr_bit),
        .sync_ok   (sync_ok),
        .arm       (arm),
        .flag_set  (flag_set)
    );

endmodule

// File: rtl/rwf_checker.sv
module rwf_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       sw_rst,
    input logic       dormant,
    input logic [1:0] mode,
    input logic [1:0] glitch_sel,
    input logic       rx_raw,
    input logic       char_done,
    input logic       addr_bit,
    input logic       idle_det,
    input logic       brk_det,
    input logic       sync_ok,
    input logic       rx_filt,
    input logic       flag_set
);

    AST_FLAG_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        flag_set |-> char_done); // R10

    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst |-> !flag_set); // R1

    AST_HOLD_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst |=> rx_filt); // R1

    AST_AWAKE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_rst && !dormant && char_done) |-> flag_set); // R2

    AST_PLAIN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_rst && mode == 2'd0 && char_done) |-> flag_set); // R3

    AST_ADDR_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_rst && dormant && mode == 2'd2 && char_done) |-> (flag_set == addr_bit)); // R6

    AST_IDLE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_set && dormant && mode == 2'd1 && !idle_det)
            |=> !(flag_set && dormant && mode == 2'd1)); // R5

    AST_SYNC_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_rst && dormant && mode == 2'd3 && char_done && !sync_ok) |-> !flag_set); // R8

endmodule

bind rx_wake_filter rwf_checker u_rwf_checker (.*);

// File: tb/tb_rx_wake_filter.sv
`timescale 1ns/1ps
module tb_rx_wake_filter;

    localparam int SYNC = 2;
    localparam int LENS [4] = '{1, 4, 6, 10};

    logic       clk = 1'b0;
    logic       rst_n;
    logic       sw_rst;
    logic       dormant;
    logic [1:0] mode;
    logic [1:0] glitch_sel;
    logic       rx_raw;
    logic       char_done;
    logic       addr_bit;
    logic       idle_det;
    logic       brk_det;
    logic       sync_ok;
    logic       rx_filt;
    logic       flag_set;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // reference model state
    bit m_idle, m_brk;
    bit m_sync [SYNC];
    int m_cnt;
    bit m_lvl;
    bit last_flag;

    always #10 clk = ~clk;

    rx_wake_filter dut (
        .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .dormant(dormant),
        .mode(mode), .glitch_sel(glitch_sel), .rx_raw(rx_raw),
        .char_done(char_done), .addr_bit(addr_bit), .idle_det(idle_det),
        .brk_det(brk_det), .sync_ok(sync_ok), .rx_filt(rx_filt),
        .flag_set(flag_set)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit model_flag();
        bit q;
        if (sw_rst || !char_done) return 1'b0;
        if (!dormant) return 1'b1;
        case (mode)
            2'd0: q = 1'b1;
            2'd1: q = m_idle;
            2'd2: q = addr_bit;
            default: q = m_brk && sync_ok;
        endcase
        return q;
    endfunction

    function automatic string flag_tag();
        if (sw_rst) return "R1";
        if (!char_done) return "R10";
        if (!dormant) return "R2";
        case (mode)
            2'd0: return "R3";
            2'd1: return "R4";
            2'd2: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic model_reset();
        m_idle = 0; m_brk = 0; m_cnt = 0; m_lvl = 1;
        for (int i = 0; i < SYNC; i++) m_sync[i] = 1;
    endtask

    task automatic model_step();
        bit s;
        if (!rst_n || sw_rst) begin
            model_reset();
            return;
        end
        m_idle = idle_det || (m_idle && !char_done);
        m_brk  = brk_det  || (m_brk  && !char_done);
        s = m_sync[SYNC-1];
        if (s == m_lvl) m_cnt = 0;
        else if (m_cnt + 1 >= LENS[glitch_sel]) begin
            m_cnt = 0;
            m_lvl = s;
        end else m_cnt = m_cnt + 1;
        for (int i = SYNC-1; i > 0; i--) m_sync[i] = m_sync[i-1];
        m_sync[0] = rx_raw;
    endtask

    // one clock: inputs already driven after a falling edge
    task automatic cyc(input bit cd = 0, input bit ad = 0, input bit id = 0,
                       input bit bk = 0, input bit so = 0);
        char_done = cd; addr_bit = ad; idle_det = id; brk_det = bk; sync_ok = so;
        #5;
        last_flag = flag_set;
        chk(flag_set == model_flag(), flag_tag(), flag_set, model_flag());
        chk(rx_filt == m_lvl, "R11", rx_filt, m_lvl);
        @(posedge clk);
        model_step();
        @(negedge clk);
        char_done = 0; addr_bit = 0; idle_det = 0; brk_det = 0; sync_ok = 0;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int lat;
        model_reset();
        rst_n = 0; sw_rst = 1; dormant = 0; mode = 0; glitch_sel = 2'd3; rx_raw = 1;
        char_done = 0; addr_bit = 0; idle_det = 0; brk_det = 0; sync_ok = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        chk(rx_filt == 1, "R1", rx_filt, 1);
        chk(flag_set == 0, "R1", flag_set, 0);
        // R1: character during hold is silent
        cyc(1);
        chk(last_flag == 0, "R1", last_flag, 0);
        sw_rst = 0;

        // R2: awake, every mode
        for (int m = 0; m < 4; m++) begin
            mode = m[1:0];
            cyc(1);
            chk(last_flag == 1, "R2", last_flag, 1);
        end

        // R3: plain mode ignores dormant
        dormant = 1; mode = 2'd0;
        cyc(1);
        chk(last_flag == 1, "R3", last_flag, 1);

        // R4/R5: idle-line
        mode = 2'd1;
        cyc(1);
        chk(last_flag == 0, "R4", last_flag, 0);
        cyc(0, 0, 1);
        cyc(); cyc();
        cyc(1);
        chk(last_flag == 1, "R4", last_flag, 1);
        cyc(1);
        chk(last_flag == 0, "R5", last_flag, 0);
        // idle in same cycle as character qualifies only the next one
        cyc(1, 0, 1);
        chk(last_flag == 0, "R4", last_flag, 0);
        cyc(1);
        chk(last_flag == 1, "R4", last_flag, 1);

        // R6: address-bit
        mode = 2'd2;
        cyc(1, 0);
        chk(last_flag == 0, "R6", last_flag, 0);
        cyc(1, 1);
        chk(last_flag == 1, "R6", last_flag, 1);

        // R9: dormant cleared in the completion cycle
        dormant = 0;
        cyc(1, 0);
        chk(last_flag == 1, "R9", last_flag, 1);
        dormant = 1;

        // R7/R8: automatic baud
        mode = 2'd3;
        cyc(0, 0, 0, 1);
        cyc();
        cyc(1, 0, 0, 0, 1);
        chk(last_flag == 1, "R7", last_flag, 1);
        cyc(1, 0, 0, 0, 1);
        chk(last_flag == 0, "R8", last_flag, 0);
        cyc(0, 0, 0, 1);
        cyc(1);
        chk(last_flag == 0, "R8", last_flag, 0);
        cyc(1, 0, 0, 0, 1);
        chk(last_flag == 0, "R8", last_flag, 0);

        // R1: hold discards pending qualification
        mode = 2'd1;
        cyc(0, 0, 1);
        sw_rst = 1; cyc(); sw_rst = 0;
        cyc(1);
        chk(last_flag == 0, "R1", last_flag, 0);

        // R11: deglitch latency per select
        for (int s = 0; s < 4; s++) begin
            glitch_sel = s[1:0];
            rx_raw = 1;
            repeat (14) cyc();
            rx_raw = 0;
            lat = 0;
            for (int k = 0; k < 20; k++) begin
                cyc();
                lat++;
                #1;
                if (rx_filt == 0) break;
            end
            chk(lat == SYNC + LENS[s], "R11", lat, SYNC + LENS[s]);
            rx_raw = 1;
            repeat (14) cyc();
            chk(rx_filt == 1, "R11", rx_filt, 1);
        end

        // R12: pulses one clock shorter than the window
        for (int s = 1; s < 4; s++) begin
            glitch_sel = s[1:0];
            rx_raw = 0;
            repeat (LENS[s] - 1) cyc();
            rx_raw = 1;
            repeat (14) begin
                cyc();
                #1;
                chk(rx_filt == 1, "R12", rx_filt, 1);
            end
        end

        // R10: mixed traffic, continuous comparison inside cyc
        dormant = 1;
        for (int i = 0; i < 200; i++) begin
            mode = 2'(i % 4);
            cyc((i % 3) == 0, (i % 5) == 0, (i % 7) == 0, (i % 11) == 0, (i % 2) == 0);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule